// File: doc/BRIEF.md
# Delay Measurement Sweep Controller

This controller finds the length of an unknown delay with two programmable delay paths and one sampling flip-flop. Each trial fires a single launch edge into both paths at the same time. The reference path is held at its minimum setting and drives the device under test. The output of the device under test goes to the data input of the flip-flop. The second path is set by a 10-bit code, and its output clocks the flip-flop.

If the flip-flop reads high, the programmed edge came too late and the code must fall. If it reads low, the programmed edge came too early and the code must rise. The controller settles one code bit per trial, from the most significant bit down. It then confirms the boundary it found by checking that the sample changes between the code it settled on and the next code up. The result is the lowest code that samples high. That is the code at which the flip-flop dithers, and it maps directly to the measured delay.

A start pulse begins a measurement. A one-cycle done pulse returns the result together with an out-of-range flag.

Top module: `delay_sweep_ctrl`

## Requirements
- R1: After reset, code_o is 0, load_n_o is 1, and launch_o, ref_min_o, done_o, result_o and range_err_o are all 0.
- R2: code_o changes only in a cycle where load_n_o is low. Each trial holds load_n_o low for exactly one cycle, so the path locks on the code presented in that cycle.
- R3: launch_o is a single-cycle pulse. It rises exactly SETTLE cycles after load_n_o returns high, and only while load_n_o is high.
- R4: The search starts at the most significant bit. The first trial code is 512. A high sample clears the bit under test, so after a high first sample the second trial is 256.
- R5: A low sample keeps the bit under test, so after a low first sample the second trial is 768.
- R6: For any threshold T from 1 to 1023 (the sample is high exactly when the locked code is at least T), the controller reports result_o = T with range_err_o = 0. Such a measurement uses 12 launches: 10 for the search and 2 for the confirmation.
- R7: If the sample is high at every code, the controller reports range_err_o = 1 and result_o = 0 after 11 launches.
- R8: If the sample is low at every code, the controller reports range_err_o = 1 and result_o = 1023 after 11 launches.
- R9: ref_min_o is high from the cycle after start until done_o. It falls in the same cycle that done_o rises, and every launch happens while it is high.
- R10: A start pulse during a measurement has no effect. Only one done pulse follows, and its result belongs to the measurement already running.
- R11: done_o is high for exactly one cycle. result_o and range_err_o keep their values until the next measurement finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a measurement when the controller is idle |
| sample_i | input | 1 | Output of the sampling flip-flop |
| code_o | output | 10 | Code for the programmable delay path |
| load_n_o | output | 1 | Low: path follows code_o; rising edge locks it |
| ref_min_o | output | 1 | Holds the reference path at its minimum delay |
| launch_o | output | 1 | Trigger edge sent to both delay paths |
| done_o | output | 1 | One-cycle end-of-measurement pulse |
| result_o | output | 10 | Measured code |
| range_err_o | output | 1 | Delay outside the programmable range |

## Verification
A wrong bit decision inside the search register is already visible at the second trial code on the path port, about one trial after start. At the end it shows as a result that is off by a power of two. A wrong sequencing counter moves the launch edge relative to the lock edge, so the trial spacing breaks within the first trial. A wrong confirmation branch lets an out-of-range delay finish without the error flag, or changes the launch count from 11 or 12. The scoreboard compares the result, the flag, the launch count and the first two trial codes for thresholds at both range ends, at the midpoint, and next to it.

// File: rtl/delay_sweep_ctrl.sv
module delay_sweep_ctrl #(
  parameter int CODE_W  = 10,
  parameter int SETTLE  = 4,
  parameter int CAPTURE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              sample_i,
  output logic [CODE_W-1:0] code_o,
  output logic              load_n_o,
  output logic              ref_min_o,
  output logic              launch_o,
  output logic              done_o,
  output logic [CODE_W-1:0] result_o,
  output logic              range_err_o
);
  localparam int MAXW  = (SETTLE > CAPTURE) ? SETTLE : CAPTURE;
  localparam int CNT_W = $clog2(MAXW + 1);
  localparam logic [CODE_W-1:0] ONE = 1;
  localparam logic [CODE_W-1:0] TOP = ONE << (CODE_W - 1);

  typedef enum logic [2:0] {IDLE, LOAD, LOCK, FIRE, CAPT} st_t;
  typedef enum logic [1:0] {P_SAR, P_LOW, P_HIGH} ph_t;

  st_t               state;
  ph_t               phase;
  logic [CNT_W-1:0]  cnt;
  logic [CODE_W-1:0] mask;

  wire               decide  = (state == CAPT) && (cnt == '0);
  wire [CODE_W-1:0]  settled = sample_i ? (code_o & ~mask) : code_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= IDLE;
      phase       <= P_SAR;
      cnt         <= '0;
      mask        <= '0;
      code_o      <= '0;
      load_n_o    <= 1'b1;
      ref_min_o   <= 1'b0;
      launch_o    <= 1'b0;
      done_o      <= 1'b0;
      result_o    <= '0;
      range_err_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        IDLE: if (start_i) begin
          state     <= LOAD;
          phase     <= P_SAR;
          mask      <= TOP;
          code_o    <= TOP;
          load_n_o  <= 1'b0;
          ref_min_o <= 1'b1;
        end
        LOAD: begin
          load_n_o <= 1'b1;
          cnt      <= CNT_W'(SETTLE - 1);
          state    <= LOCK;
        end
        LOCK: begin
          if (cnt == '0) begin
            launch_o <= 1'b1;
            state    <= FIRE;
          end else cnt <= cnt - 1'b1;
        end
        FIRE: begin
          launch_o <= 1'b0;
          cnt      <= CNT_W'(CAPTURE - 1);
          state    <= CAPT;
        end
        CAPT: begin
          if (!decide) cnt <= cnt - 1'b1;
          else begin
            case (phase)
              P_SAR: begin
                state    <= LOAD;
                load_n_o <= 1'b0;
                if (mask[0]) begin
                  phase  <= P_LOW;
                  code_o <= settled;
                end else begin
                  code_o <= settled | (mask >> 1);
                  mask   <= mask >> 1;
                end
              end
              P_LOW: begin
                if (sample_i || (&code_o)) begin
                  state       <= IDLE;
                  done_o      <= 1'b1;
                  ref_min_o   <= 1'b0;
                  result_o    <= code_o;
                  range_err_o <= 1'b1;
                end else begin
                  phase    <= P_HIGH;
                  code_o   <= code_o + ONE;
                  state    <= LOAD;
                  load_n_o <= 1'b0;
                end
              end
              default: begin
                state       <= IDLE;
                done_o      <= 1'b1;
                ref_min_o   <= 1'b0;
                result_o    <= sample_i ? code_o : code_o - ONE;
                range_err_o <= !sample_i;
              end
            endcase
          end
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/delay_sweep_ctrl_chk.sv
module delay_sweep_ctrl_chk #(
  parameter int CODE_W  = 10,
  parameter int SETTLE  = 4,
  parameter int CAPTURE = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              sample_i,
  input logic [CODE_W-1:0] code_o,
  input logic              load_n_o,
  input logic              ref_min_o,
  input logic              launch_o,
  input logic              done_o,
  input logic [CODE_W-1:0] result_o,
  input logic              range_err_o
);
  logic [15:0] since_lock;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_lock <= '0;
    else if (!load_n_o) since_lock <= '0;
    else if (since_lock != 16'hFFFF) since_lock <= since_lock + 16'd1;
  end

  AST_CODE_ONLY_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n) !$stable(code_o) |-> !load_n_o); // R2
  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) !load_n_o |=> load_n_o); // R2
  AST_LAUNCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n) launch_o |=> !launch_o); // R3
  AST_LAUNCH_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) launch_o |-> load_n_o); // R3
  AST_LAUNCH_SETTLED: assert property (@(posedge clk) disable iff (!rst_n) $rose(launch_o) |-> since_lock == 16'(SETTLE)); // R3
  AST_LAUNCH_REFMIN: assert property (@(posedge clk) disable iff (!rst_n) launch_o |-> ref_min_o); // R9
  AST_REFMIN_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(ref_min_o) |-> done_o); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R11
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n) !done_o |-> $stable(result_o) && $stable(range_err_o)); // R11
  AST_OK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) (done_o && !range_err_o) |-> result_o != '0); // R6
endmodule

bind delay_sweep_ctrl delay_sweep_ctrl_chk #(.CODE_W(CODE_W), .SETTLE(SETTLE), .CAPTURE(CAPTURE)) u_chk (.*);

// File: tb/delay_sweep_ctrl_test.sv
module delay_sweep_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic sample_i = 1'b0;
  logic [9:0] code_o, result_o;
  logic load_n_o, ref_min_o, launch_o, done_o, range_err_o;

  always #4 clk = ~clk;

  delay_sweep_ctrl uut (.clk(clk), .rst_n(rst_n), .start_i(start_i), .sample_i(sample_i),
    .code_o(code_o), .load_n_o(load_n_o), .ref_min_o(ref_min_o), .launch_o(launch_o),
    .done_o(done_o), .result_o(result_o), .range_err_o(range_err_o));

  typedef struct packed {
    logic [9:0] res;
    logic       err;
    logic [9:0] second;
    logic [7:0] launches;
  } exp_t;

  exp_t sb[$];
  int compared = 0, mismatched = 0;
  int thr = 0;
  logic [9:0] locked = '0;
  int n_launch = 0;
  logic [9:0] codes [0:1];
  int refmin_bad = 0;
  int done_seen = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // Delay path, DUT and sampling flop model
  always @(negedge clk) begin
    if (!load_n_o) locked <= code_o;
    if (launch_o) begin
      sample_i <= (int'(locked) >= thr);
      if (n_launch < 2) codes[n_launch] <= locked;
      n_launch <= n_launch + 1;
      if (!ref_min_o) refmin_bad <= refmin_bad + 1;
    end
  end

  // Monitor
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      exp_t e;
      done_seen++;
      if (sb.size() == 0) check(0, "R10 unexpected done", 1, 0);
      else begin
        e = sb.pop_front();
        check(result_o == e.res, "R6/R7/R8 result", result_o, e.res);
        check(range_err_o == e.err, "R6/R7/R8 range_err", range_err_o, e.err);
        check(n_launch == int'(e.launches), "R6 launch count", n_launch, e.launches);
        check(codes[0] == 10'd512, "R4 first trial code", codes[0], 512);
        check(codes[1] == e.second, "R4/R5 second trial code", codes[1], e.second);
        check(refmin_bad == 0, "R9 launch without ref_min", refmin_bad, 0);
        check(ref_min_o == 1'b0, "R9 ref_min falls with done", ref_min_o, 0);
      end
      n_launch <= 0;
    end
  end

  task automatic measure(input int t, input bit poke_busy);
    exp_t e;
    e.err      = (t == 0) || (t >= 1024);
    e.res      = (t == 0) ? 10'd0 : (t >= 1024) ? 10'd1023 : 10'(t);
    e.launches = e.err ? 8'd11 : 8'd12;
    e.second   = (t <= 512) ? 10'd256 : 10'd768;
    sb.push_back(e);
    thr = t;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    if (poke_busy) begin
      repeat (40) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(code_o == 0, "R1 code", code_o, 0);
    check(load_n_o == 1, "R1 load_n", load_n_o, 1);
    check(launch_o == 0 && done_o == 0, "R1 launch/done", launch_o | done_o, 0);
    check(ref_min_o == 0, "R1 ref_min", ref_min_o, 0);
    check(result_o == 0 && range_err_o == 0, "R1 result/err", result_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    measure(512, 0);   // R4 high first sample at boundary
    measure(513, 0);   // R5 low first sample
    measure(37, 0);    // R6
    measure(1, 0);     // R6 lower edge
    measure(1023, 0);  // R6 upper edge
    measure(0, 0);     // R7 always high
    measure(1024, 0);  // R8 never high
    measure(300, 1);   // R10 start while busy

    repeat (30) @(negedge clk);
    check(done_seen == 8, "R10 done count", done_seen, 8);
    check(result_o == 10'd300 && range_err_o == 0, "R11 result held", result_o, 300);
    check(sb.size() == 0, "R11 scoreboard drained", sb.size(), 0);
    check(load_n_o == 1 && ref_min_o == 0, "R9 idle outputs", ref_min_o, 0);
    wrap_up();
  end

  initial begin
    repeat (50000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    wrap_up();
  end
endmodule